// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execute Unit

This unit carries out the second byte of a two-byte bit-manipulation instruction of an 8-bit CPU, the byte that follows the 0xCB prefix. The CPU fetches the prefix and then hands the opcode byte over with a one-clock start strobe. The unit can exchange the two nibbles of an operand (SWAP), test one bit (BIT), clear one bit (RES) or set one bit (SET). It reads and writes a small 8-bit register file through a read-select and write port. It also produces the new value of the flag byte. The unit ends every instruction with a one-clock done pulse that carries the cycle cost of the instruction.

When the operand field names the byte addressed by HL, the unit does not touch the register file. It raises a request on a simple memory port that is held until acknowledged, with the address taken from the `hlAddr` input. BIT then finishes on the read data. SWAP, SET and RES issue a second request that writes the result back. Opcodes outside the supported groups raise an illegal-opcode output, and no register, flag or memory write takes place for them. The instruction is exactly two bytes long, so the next byte after the opcode belongs to the following instruction.

Top module: `prefix_bitops_unit`

## Requirements
- R1: Opcode decode: 0x30..0x37 is SWAP, 0x40..0x7F is BIT, 0x80..0xBF is RES, 0xC0..0xFF is SET. For BIT, RES and SET, opcode bits [5:3] give the bit index. Every other value (0x00..0x2F, 0x38..0x3F) is illegal.
- R2: Opcode bits [2:0] select the operand. Codes 0..5 are register-file entries B, C, D, E, H, L at that same index and code 7 is A at index 7. Code 6 is the memory byte at `hlAddr` and never reads or writes the register file.
- R3: SWAP writes {v[3:0], v[7:4]} back to the selected operand, where v is the operand value (0xA5 becomes 0x5A, 0xFF stays 0xFF).
- R4: After SWAP the written flag byte is 0x80 when the result is 0x00 and 0x00 otherwise. Flag positions are Z=7, N=6, H=5, C=4.
- R5: BIT writes flags with Z = inverse of the tested bit, N = 0, H = 1 and C kept from `flagsIn`, and it writes no operand.
- R6: RES clears and SET sets the indexed bit of the operand and writes it back. Neither writes the flags.
- R7: Bits [3:0] of every flag byte written are zero.
- R8: `cycleCount` is 8 for any register operand, 12 for BIT on the memory operand and 16 for SWAP/RES/SET on the memory operand. It is valid only while `done` is high and is 0 in every other clock.
- R9: `done` lasts one clock. For a register operand or an illegal opcode it comes in the clock after the start edge. For the memory operand, BIT completes in the clock after the read is acknowledged, and the other operations complete in the clock in which the write is acknowledged.
- R10: An illegal opcode gives `illegalOp` high together with `done`, `cycleCount` 0, and no register, flag or memory request.
- R11: A start strobe that arrives while an instruction is in progress is ignored.
- R12: `memReq` is raised only for the memory operand of a legal opcode, with `memAddr` equal to `hlAddr`. It is held, with an unchanged direction, until `memAck`.
- R13: After reset the unit is idle with `done`, `memReq`, `rfWrEn`, `flagsWrEn` low and `cycleCount` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-clock strobe that starts an instruction |
| opByte | input | 8 | Opcode byte following the prefix, valid with `startPulse` |
| flagsIn | input | 8 | Current flag byte |
| hlAddr | input | ADDR_W | Address held in HL, used for the memory operand |
| rfRdSel | output | 3 | Register-file read index |
| rfRdData | input | 8 | Register-file read data (combinational on `rfRdSel`) |
| rfWrEn | output | 1 | Register-file write strobe |
| rfWrSel | output | 3 | Register-file write index |
| rfWrData | output | 8 | Register-file write data |
| flagsWrEn | output | 1 | Flag byte write strobe |
| flagsOut | output | 8 | New flag byte |
| memReq | output | 1 | Memory request, held until `memAck` |
| memWe | output | 1 | Request direction: 1 write, 0 read |
| memAddr | output | ADDR_W | Memory address |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Memory acknowledge |
| done | output | 1 | One-clock completion pulse |
| illegalOp | output | 1 | Opcode not supported, valid with `done` |
| cycleCount | output | CYC_W | Cycle cost of the instruction, valid with `done` |

## Verification
A behavioural model in the bench predicts the result, flags, cycle cost and completion clock, and these are compared clock by clock. The nibble exchange uses asymmetric values (0xA5, 0x3C) to catch a missing or half exchange, 0xFF to catch a fixed pattern, and 0x00 against a nonzero value to separate zero-flag set from zero-flag clear, with every stale flag set beforehand. BIT is tested at both ends of the bit range with the carry flag preset both ways, which shows whether C is kept and whether Z is inverted. A sweep over all 256 opcodes, with a different register pattern and memory latencies of 0, 1 and 2, tells apart the decode boundaries, the operand routing, the memory path timing and the quiet handling of illegal codes. A start strobe in the middle of a memory operation shows whether a busy unit can be restarted.

// File: rtl/pbu_pkg.sv
package pbu_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;

  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  typedef enum logic [2:0] {
    K_ILLEGAL,
    K_SWAP,
    K_BIT,
    K_RES,
    K_SET
  } opKind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_CALC
  } ctrlState_e;

  // Strobes from control into the datapath
  typedef struct packed {
    logic latchOp;
    logic latchMem;
  } dpStrobe_t;

  function automatic opKind_e decodeKind(input logic [BYTE_W-1:0] op);
    opKind_e k;
    case (op[7:6])
      2'b11:   k = K_SET;
      2'b10:   k = K_RES;
      2'b01:   k = K_BIT;
      default: k = (op[5:3] == 3'b110) ? K_SWAP : K_ILLEGAL;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/pbu_datapath.sv
module pbu_datapath
  import pbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] opByte,
  input  logic [BYTE_W-1:0] rfRdData,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic [BYTE_W-1:0] flagsIn,
  output opKind_e           kind,
  output logic              memOperand,
  output logic [SEL_W-1:0]  operandSel,
  output logic [BYTE_W-1:0] result,
  output logic [BYTE_W-1:0] flagsNext
);

  localparam int NIB_W = BYTE_W / 2;

  logic [BYTE_W-1:0] opReg;
  logic [BYTE_W-1:0] memVal;
  logic [BYTE_W-1:0] opnd;
  logic [BYTE_W-1:0] bitMask;
  logic [2:0]        bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= '0;
      memVal <= '0;
    end else begin
      if (strobe.latchOp)  opReg  <= opByte;
      if (strobe.latchMem) memVal <= memRdData;
    end
  end

  assign kind       = decodeKind(opReg);
  assign operandSel = opReg[SEL_W-1:0];
  assign memOperand = (operandSel == SEL_MEM);
  assign bitIdx     = opReg[5:3];
  assign opnd       = memOperand ? memVal : rfRdData;
  assign bitMask    = BYTE_W'(1) << bitIdx;

  always_comb begin
    result    = opnd;
    flagsNext = flagsIn & 8'hF0;
    unique case (kind)
      K_SWAP: begin
        result            = {opnd[NIB_W-1:0], opnd[BYTE_W-1:NIB_W]};
        flagsNext         = '0;
        flagsNext[FLAG_Z] = (opnd == '0);
      end
      K_BIT: begin
        flagsNext[FLAG_Z] = ~opnd[bitIdx];
        flagsNext[FLAG_N] = 1'b0;
        flagsNext[FLAG_H] = 1'b1;
      end
      K_RES:   result = opnd & ~bitMask;
      K_SET:   result = opnd | bitMask;
      default: ;
    endcase
  end

  // R4: zero flag of SWAP agrees with the written byte
  p_swap_zero_r4 : assert property (@(posedge clk) disable iff (!rstN)
    (kind == K_SWAP) |-> (flagsNext[FLAG_Z] == (result == '0)));

  // R5: BIT keeps carry and raises half-carry
  p_bit_flags_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (kind == K_BIT) |-> (flagsNext[FLAG_C] == flagsIn[FLAG_C]) && flagsNext[FLAG_H]);

  // R5: BIT leaves the operand value untouched
  p_bit_keeps_opnd_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (kind == K_BIT) |-> (result == opnd));

endmodule

// File: rtl/pbu_ctrl.sv
module pbu_ctrl
  import pbu_pkg::*;
#(
  parameter int REG_CYCLES     = 8,
  parameter int BIT_MEM_CYCLES = 12,
  parameter int RMW_MEM_CYCLES = 16,
  parameter int CYC_W          = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  opKind_e          kind,
  input  logic             memOperand,
  input  logic             memAck,
  output dpStrobe_t        strobe,
  output logic             done,
  output logic             illegalOp,
  output logic             rfWrEn,
  output logic             flagsWrEn,
  output logic             memReq,
  output logic             memWe,
  output logic [CYC_W-1:0] cycleCount
);

  ctrlState_e state, stateNext;
  logic writesOperand;
  logic writesFlags;

  assign writesOperand = (kind == K_SWAP) || (kind == K_RES) || (kind == K_SET);
  assign writesFlags   = (kind == K_SWAP) || (kind == K_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    done      = 1'b0;
    illegalOp = 1'b0;
    rfWrEn    = 1'b0;
    flagsWrEn = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startPulse) begin
          strobe.latchOp = 1'b1;
          stateNext      = S_RUN;
        end
      end
      S_RUN: begin
        if (kind == K_ILLEGAL) begin
          done      = 1'b1;
          illegalOp = 1'b1;
          stateNext = S_IDLE;
        end else if (!memOperand) begin
          done      = 1'b1;
          rfWrEn    = writesOperand;
          flagsWrEn = writesFlags;
          stateNext = S_IDLE;
        end else begin
          memReq = 1'b1;
          if (memAck) begin
            strobe.latchMem = 1'b1;
            stateNext       = S_CALC;
          end
        end
      end
      S_CALC: begin
        if (kind == K_BIT) begin
          done      = 1'b1;
          flagsWrEn = 1'b1;
          stateNext = S_IDLE;
        end else begin
          memReq = 1'b1;
          memWe  = 1'b1;
          if (memAck) begin
            done      = 1'b1;
            flagsWrEn = (kind == K_SWAP);
            stateNext = S_IDLE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    cycleCount = '0;
    if (done && !illegalOp) begin
      if (!memOperand)         cycleCount = CYC_W'(REG_CYCLES);
      else if (kind == K_BIT)  cycleCount = CYC_W'(BIT_MEM_CYCLES);
      else                     cycleCount = CYC_W'(RMW_MEM_CYCLES);
    end
  end

  // R9: completion pulse is one clock wide
  p_done_single_r9 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: writebacks happen only at completion
  p_write_at_done_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn || flagsWrEn) |-> done);

  // R10: illegal opcode is quiet
  p_illegal_quiet_r10 : assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (!rfWrEn && !flagsWrEn && !memReq && (cycleCount == '0)));

  // R8: cost reported only with done
  p_cycles_only_done_r8 : assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (cycleCount == '0));

  // R12: request held with stable direction until acknowledged
  p_req_held_r12 : assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R11: a start strobe while busy does not restart the opcode latch
  p_start_ignored_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !strobe.latchOp);

endmodule

// File: rtl/prefix_bitops_unit.sv
module prefix_bitops_unit
  import pbu_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int REG_CYCLES     = 8,
  parameter int BIT_MEM_CYCLES = 12,
  parameter int RMW_MEM_CYCLES = 16,
  parameter int CYC_W          = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [7:0]        opByte,
  input  logic [7:0]        flagsIn,
  input  logic [ADDR_W-1:0] hlAddr,
  output logic [2:0]        rfRdSel,
  input  logic [7:0]        rfRdData,
  output logic              rfWrEn,
  output logic [2:0]        rfWrSel,
  output logic [7:0]        rfWrData,
  output logic              flagsWrEn,
  output logic [7:0]        flagsOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  input  logic              memAck,
  output logic              done,
  output logic              illegalOp,
  output logic [CYC_W-1:0]  cycleCount
);

  dpStrobe_t         strobe;
  opKind_e           kind;
  logic              memOperand;
  logic [SEL_W-1:0]  operandSel;
  logic [BYTE_W-1:0] result;

  pbu_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opByte     (opByte),
    .rfRdData   (rfRdData),
    .memRdData  (memRdData),
    .flagsIn    (flagsIn),
    .kind       (kind),
    .memOperand (memOperand),
    .operandSel (operandSel),
    .result     (result),
    .flagsNext  (flagsOut)
  );

  pbu_ctrl #(
    .REG_CYCLES     (REG_CYCLES),
    .BIT_MEM_CYCLES (BIT_MEM_CYCLES),
    .RMW_MEM_CYCLES (RMW_MEM_CYCLES),
    .CYC_W          (CYC_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .kind       (kind),
    .memOperand (memOperand),
    .memAck     (memAck),
    .strobe     (strobe),
    .done       (done),
    .illegalOp  (illegalOp),
    .rfWrEn     (rfWrEn),
    .flagsWrEn  (flagsWrEn),
    .memReq     (memReq),
    .memWe      (memWe),
    .cycleCount (cycleCount)
  );

  assign rfRdSel   = operandSel;
  assign rfWrSel   = operandSel;
  assign rfWrData  = result;
  assign memAddr   = hlAddr;
  assign memWrData = result;

  // R7: low nibble of any written flag byte is zero
  p_flags_low_zero_r7 : assert property (@(posedge clk) disable iff (!rstN)
    flagsWrEn |-> (flagsOut[3:0] == 4'h0));

  // R2: memory operand never writes the register file
  p_no_rf_for_mem_r2 : assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrSel != SEL_MEM));

  // R12: memory requests only for the memory operand code
  p_req_only_mem_r12 : assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (rfRdSel == SEL_MEM));

endmodule

// File: tb/prefix_bitops_unit_tb_top.sv
`timescale 1ns/1ps
module prefix_bitops_unit_tb_top;

  localparam int ADDR_W = 16;
  localparam int CYC_W  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic              startPulse = 1'b0;
  logic [7:0]        opByte = 8'h00;
  logic [7:0]        flagsIn;
  logic [ADDR_W-1:0] hlAddr = '0;
  logic [2:0]        rfRdSel;
  logic [7:0]        rfRdData;
  logic              rfWrEn;
  logic [2:0]        rfWrSel;
  logic [7:0]        rfWrData;
  logic              flagsWrEn;
  logic [7:0]        flagsOut;
  logic              memReq;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWrData;
  logic [7:0]        memRdData = 8'h00;
  logic              memAck = 1'b0;
  logic              done;
  logic              illegalOp;
  logic [CYC_W-1:0]  cycleCount;

  logic [7:0] regs [8];
  logic [7:0] mem  [256];
  logic [7:0] flagReg;
  int ackDelay = 0;
  int reqCnt = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  prefix_bitops_unit #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opByte(opByte),
    .flagsIn(flagsIn), .hlAddr(hlAddr), .rfRdSel(rfRdSel), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrSel(rfWrSel), .rfWrData(rfWrData),
    .flagsWrEn(flagsWrEn), .flagsOut(flagsOut), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .memAck(memAck), .done(done), .illegalOp(illegalOp), .cycleCount(cycleCount)
  );

  // Environment: register file, flag register, memory with programmable latency
  assign rfRdData = regs[rfRdSel];
  assign flagsIn  = flagReg;

  always @(posedge clk) begin
    if (rfWrEn)    regs[rfWrSel] <= rfWrData;
    if (flagsWrEn) flagReg <= flagsOut;
  end

  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
      reqCnt = 0;
    end else if (memReq) begin
      if (reqCnt == ackDelay) begin
        memAck    = 1'b1;
        memRdData = mem[memAddr[7:0]];
        if (memWe) mem[memAddr[7:0]] = memWrData;
      end else begin
        reqCnt++;
      end
    end else begin
      reqCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference of one instruction, written from the requirements
  typedef enum int {M_ILL, M_SWAP, M_BIT, M_RES, M_SET} mKind_e;

  function automatic mKind_e classify(input logic [7:0] op);
    if (op >= 8'h30 && op <= 8'h37) return M_SWAP;
    if (op >= 8'h40 && op <= 8'h7F) return M_BIT;
    if (op >= 8'h80 && op <= 8'hBF) return M_RES;
    if (op >= 8'hC0)                return M_SET;
    return M_ILL;
  endfunction

  task automatic runOp(input logic [7:0] op, input int d, input bit poke);
    mKind_e mk = classify(op);
    int sel = int'(op[2:0]);
    bit isMem = (sel == 6);
    int b = (int'(op) / 8) % 8;
    logic [7:0] v = isMem ? mem[hlAddr[7:0]] : regs[sel];
    logic [7:0] res = v;
    logic [7:0] expFlagReg = flagReg;
    logic [7:0] expRegs [8];
    logic [7:0] expMemVal = mem[hlAddr[7:0]];
    int expCyc = 0;
    int expWin;
    bit timingOk = 1'b1;
    bit illOk = 1'b1;
    bit cycOk = 1'b1;
    bit reqOk = 1'b1;
    bit regOk = 1'b1;
    int doneCnt = 0;
    int seenCyc = 0;
    string tagRes;
    string tagFlg;

    case (mk)
      M_SWAP: begin
        res = {v[3:0], v[7:4]};
        expFlagReg = (res == 8'h00) ? 8'h80 : 8'h00;
      end
      M_BIT:  expFlagReg = (v[b] ? 8'h00 : 8'h80) | 8'h20 | (flagReg & 8'h10);
      M_RES:  res = v & ~(8'h01 << b);
      M_SET:  res = v | (8'h01 << b);
      default: ;
    endcase
    for (int i = 0; i < 8; i++) expRegs[i] = regs[i];
    if (mk == M_SWAP || mk == M_RES || mk == M_SET) begin
      if (isMem) expMemVal = res;
      else       expRegs[sel] = res;
    end
    if (mk != M_ILL) expCyc = !isMem ? 8 : (mk == M_BIT ? 12 : 16);
    if (mk == M_ILL || !isMem) expWin = 1;
    else if (mk == M_BIT)      expWin = 2 + d;
    else                       expWin = 3 + 2 * d;

    tagRes = (mk == M_ILL) ? "R10" : (mk == M_SWAP) ? "R3 R2" : (mk == M_BIT) ? "R5" : "R6 R2";
    tagFlg = (mk == M_ILL) ? "R10" : (mk == M_SWAP) ? "R4 R7" : (mk == M_BIT) ? "R5 R7" : "R6";

    ackDelay = d;
    @(negedge clk);
    startPulse = 1'b1;
    opByte     = op;
    @(posedge clk);
    #1;
    startPulse = 1'b0;
    opByte     = ~op;
    for (int k = 1; k <= expWin + 2; k++) begin
      @(negedge clk);
      #1;
      if (poke && k == 2) begin
        startPulse = 1'b0;
        opByte     = 8'h00;
      end
      if (done !== (k == expWin)) timingOk = 1'b0;
      if (done) begin
        doneCnt++;
        seenCyc = int'(cycleCount);
        if (illegalOp !== (mk == M_ILL)) illOk = 1'b0;
        if (int'(cycleCount) != expCyc)  cycOk = 1'b0;
      end else if (cycleCount !== '0) begin
        cycOk = 1'b0;
      end
      if (memReq && (!isMem || mk == M_ILL || memAddr !== hlAddr)) reqOk = 1'b0;
      if (poke && k == 1) begin
        startPulse = 1'b1;
        opByte     = 8'h37;
      end
    end

    chk(timingOk && doneCnt == 1, poke ? "R11 R9" : "R9", $sformatf("done clock/count op=%02h", op), doneCnt, 1);
    chk(illOk, "R1 R10", $sformatf("illegalOp op=%02h", op), int'(illegalOp), int'(mk == M_ILL));
    chk(cycOk, "R8", $sformatf("cycleCount op=%02h", op), seenCyc, expCyc);
    chk(reqOk, "R12", $sformatf("memory request op=%02h", op), int'(memReq), 0);
    for (int i = 0; i < 8; i++) if (regs[i] !== expRegs[i]) regOk = 1'b0;
    chk(regOk, tagRes, $sformatf("register file op=%02h sel=%0d", op, sel), int'(regs[sel]), int'(expRegs[sel]));
    chk(mem[hlAddr[7:0]] === expMemVal, tagRes, $sformatf("memory byte op=%02h", op),
        int'(mem[hlAddr[7:0]]), int'(expMemVal));
    chk(flagReg === expFlagReg, tagFlg, $sformatf("flags op=%02h", op), int'(flagReg), int'(expFlagReg));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=0x%0h expected=0x%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 8'h00;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    flagReg = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1;
    chk(!done && !memReq && !rfWrEn && !flagsWrEn && cycleCount == '0, "R13",
        "idle outputs in reset", int'(done), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !memReq && !rfWrEn && !flagsWrEn && cycleCount == '0, "R13",
        "idle outputs after reset", int'(memReq), 0);

    // R3 R4: nibble exchange on registers, stale flags preset
    regs[0] = 8'hA5; flagReg = 8'hF0; runOp(8'h30, 0, 1'b0);
    regs[1] = 8'h00; flagReg = 8'h70; runOp(8'h31, 0, 1'b0);
    regs[7] = 8'hFF; flagReg = 8'hF0; runOp(8'h37, 0, 1'b0);
    regs[2] = 8'h3C; runOp(8'h32, 0, 1'b0);
    regs[5] = 8'h5A; runOp(8'h35, 0, 1'b0);
    // R5: bit test at both ends, carry preset both ways
    regs[7] = 8'h80; flagReg = 8'h10; runOp(8'h7F, 0, 1'b0);
    regs[0] = 8'hFE; flagReg = 8'h40; runOp(8'h40, 0, 1'b0);
    // R6: set and clear
    regs[2] = 8'h00; flagReg = 8'hB0; runOp(8'hDA, 0, 1'b0);
    regs[4] = 8'hFF; runOp(8'hBC, 0, 1'b0);
    // R1 R10: illegal codes, including the memory operand code
    runOp(8'h00, 0, 1'b0);
    runOp(8'h3F, 0, 1'b0);
    runOp(8'h2E, 0, 1'b0);
    // R12 R9: memory operand with several latencies
    hlAddr = 16'h1234; mem[8'h34] = 8'hC3; flagReg = 8'hF0; runOp(8'h36, 0, 1'b0);
    hlAddr = 16'h0010; mem[8'h10] = 8'h00; runOp(8'h36, 2, 1'b0);
    hlAddr = 16'h0020; mem[8'h20] = 8'h01; flagReg = 8'h00; runOp(8'h46, 1, 1'b0);
    hlAddr = 16'h0030; mem[8'h30] = 8'h00; runOp(8'hFE, 0, 1'b0);
    // R11: start while a memory operation is in progress
    hlAddr = 16'h0040; mem[8'h40] = 8'hFF; regs[7] = 8'h12; runOp(8'h86, 3, 1'b1);
    chk(regs[7] === 8'h12, "R11", "register untouched by ignored start", int'(regs[7]), 8'h12);

    // R1 R2: sweep of every opcode
    for (int op = 0; op < 256; op++) begin
      for (int i = 0; i < 8; i++) regs[i] = 8'(op * 37 + i * 11);
      flagReg = 8'((op ^ 8'h5A) & 8'hF0);
      hlAddr  = 16'(op * 3);
      runOp(8'(op), op % 3, 1'b0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule